// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Register Interface

This block is a serial peripheral interface controller. A host CPU drives it through three 8-bit registers: a control register, a status register and a data register. The block moves one byte at a time over the SPI pins. As master it divides the system clock down to make SCK and shifts the byte out while it shifts the reply in. As slave it follows an external SCK while its active-low select input is held low. Hardware drives the pins. A master that needs a chip-select for its target drives that line from a general-purpose output outside this block.

The register port is a plain single-cycle bus. Each access is one cycle with `reg_wr` or `reg_rd` high. There is no back-pressure: every access completes in the cycle it is presented. `reg_rdata` follows `reg_addr` combinationally, and `reg_rd` matters only for the read side effect on the flags. Address 0 is control, address 1 is status and address 2 is data. Writing the data register loads the shifter. In master mode that write also starts the clock. Reading the data register returns the byte captured by the most recent completed transfer. Software learns that a transfer has ended either by polling the completion flag or through the `irq` output.

Top module: `spi_regif_ctrl`

## Requirements
- R1: After reset, the control, status and data registers read 0x00, `irq` is low, `sck_o` is low and `miso_oe` is low.
- R2: Control bits, from bit 7 down to bit 0, are: interrupt enable, SPI enable, LSB-first order, master select (1 = master), clock polarity, clock phase, and rate select[1:0]. Status bit 7 is the completion flag and bit 6 the collision flag; neither can be written. Status bits 5:1 always read 0. Status bit 0 is the double-speed bit, which software can read and write.
- R3: In master mode one SCK period lasts N system clocks, where N is selected by {double-speed, rate1, rate0}: 000→4, 001→16, 010→64, 011→128, 100→2, 101→8, 110→32, 111→64.
- R4: While idle, SCK sits at the polarity level. With phase 0, data is sampled on the leading edge of each bit and the next bit is driven on the trailing edge. With phase 1, data is driven on the leading edge and sampled on the trailing edge.
- R5: With the LSB-first bit at 0, bit 7 is sent and received first. With it at 1, bit 0 is first.
- R6: A data-register write made while the block is enabled and idle starts a transfer. In master mode, the completion flag reads 1 exactly 16·N/2 clocks after the write edge, and a data read then returns the byte received.
- R7: A data-register write made while a transfer is in progress sets the collision flag. That write is ignored, so the byte on the line and the received result are those of the first write.
- R8: The completion and collision flags are cleared only by a status read made while a flag is set, followed by a data-register access. A data access with no preceding status read leaves the flags as they are.
- R9: `irq` is high exactly when both the interrupt enable bit and the completion flag are 1.
- R10: In slave mode a transfer runs only while `ss_n_i` is low. SCK edges seen while `ss_n_i` is high move no bits and do not set the completion flag.
- R11: In master mode the level of `ss_n_i` has no effect on a transfer.
- R12: With the enable bit at 0, a data write starts nothing: SCK does not move and the completion flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (for side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_i | input | 1 | Serial data in (master) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Drive enable for `sck_o` |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe | output | 1 | Drive enable for `mosi_o` |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | Drive enable for `miso_o` |

## Verification
In master mode, the first SCK edge comes N/2 clocks after the data-write edge. The completion flag rises in the same clock as the sixteenth edge. The bench therefore reads status without side effects one cycle before that point and again at it, and measures SCK periods by counting clocks between rising edges. In slave mode, the pins pass through a two-stage synchronizer, so a flag or output change lags the pin edge by three clocks. The bench keeps eight clocks between the edges it drives and samples `miso_o` just before it moves SCK. Register writes and flag effects appear one clock after the strobe edge, and every check samples on the falling clock edge.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  localparam int REG_W  = 8;
  localparam int HALF_W = 7;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } reg_addr_e;

  // Field order is the control register layout, bit 7 first.
  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // System clocks per SCK half period for {double, rate1, rate0}.
  function automatic logic [HALF_W-1:0] half_period(input logic dbl,
                                                    input logic [1:0] rate);
    logic [HALF_W-1:0] h;
    case ({dbl, rate})
      3'b000:  h = HALF_W'(2);
      3'b001:  h = HALF_W'(8);
      3'b010:  h = HALF_W'(32);
      3'b011:  h = HALF_W'(64);
      3'b100:  h = HALF_W'(1);
      3'b101:  h = HALF_W'(4);
      3'b110:  h = HALF_W'(16);
      default: h = HALF_W'(32);
    endcase
    return h;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int           N       = 3,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half,
  output logic          tick
);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          master,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          tick,
  input  logic          sck_s,
  input  logic          ss_act,
  input  logic          mosi_s,
  input  logic          miso_i,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_data,
  output logic          sck_o,
  output logic          dout
);

  localparam int ECW = $clog2(2 * DW);
  localparam int SCW = $clog2(DW);

  logic [ECW-1:0] edge_cnt;
  logic [SCW-1:0] samp_cnt;
  logic           busy_m, sck_r, sck_q, dout_r;
  logic [DW-1:0]  sr, rx_q, sr_shift;
  logic           ev, lead, samp_ev, drv_ev, in_bit, head, done_m, done_s;

  always_comb begin
    ev       = master ? (busy_m && tick) : (ss_act && (sck_s != sck_q));
    lead     = master ? ~edge_cnt[0] : (sck_s != cpol);
    samp_ev  = ev && (lead ^ cpha);
    drv_ev   = ev && !(lead ^ cpha);
    in_bit   = master ? miso_i : mosi_s;
    head     = lsb_first ? sr[0] : sr[DW-1];
    sr_shift = lsb_first ? {in_bit, sr[DW-1:1]} : {sr[DW-2:0], in_bit};
    done_m   = master && busy_m && tick && (edge_cnt == ECW'(2 * DW - 1));
    done_s   = !master && samp_ev && (samp_cnt == SCW'(DW - 1));
    done     = done_m || done_s;
    busy     = master ? busy_m : (ss_act && (samp_cnt != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      busy_m   <= 1'b0;
      edge_cnt <= '0;
      sck_r    <= 1'b0;
      samp_cnt <= '0;
      sr       <= '0;
      dout_r   <= 1'b0;
      rx_q     <= '0;
    end else begin
      sck_q <= sck_s;

      if (!enable || !master) busy_m <= 1'b0;
      else if (load)          busy_m <= 1'b1;
      else if (done_m)        busy_m <= 1'b0;

      if (!busy_m)   edge_cnt <= '0;
      else if (tick) edge_cnt <= edge_cnt + 1'b1;

      if (!busy_m)   sck_r <= cpol;
      else if (tick) sck_r <= ~sck_r;

      if (master || !ss_act) samp_cnt <= '0;
      else if (samp_ev)      samp_cnt <= (samp_cnt == SCW'(DW - 1)) ? '0 : samp_cnt + 1'b1;

      if (load)         sr <= load_data;
      else if (samp_ev) sr <= sr_shift;

      if (load && !cpha) dout_r <= lsb_first ? load_data[0] : load_data[DW-1];
      else if (drv_ev)   dout_r <= head;

      if (done) rx_q <= samp_ev ? sr_shift : sr;
    end
  end

  assign sck_o   = sck_r;
  assign dout    = dout_r;
  assign rx_data = rx_q;

  // R12: a disabled block drops out of a master transfer.
  a_r12_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy_m);

  // R4: without a transfer, SCK returns to the polarity level.
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_m |=> (sck_r == $past(cpol)));

  // R10: a deselected slave holds no partial bit count.
  a_r10_deselect_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !ss_act) |=> (samp_cnt == '0));

endmodule

// File: rtl/spi_regif_ctrl.sv
module spi_regif_ctrl
  import spi_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  input  logic             sck_i,
  input  logic             ss_n_i,
  input  logic             mosi_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             sck_oe,
  output logic             mosi_o,
  output logic             mosi_oe,
  output logic             miso_o,
  output logic             miso_oe
);

  ctrl_t            ctrl_q;
  logic             dbl_q, spif_q, wcol_q, armed_q;
  logic             eng_busy, eng_done, tick, dout, ss_act;
  logic             sck_s, ss_s, mosi_s;
  logic [REG_W-1:0] rx_data;
  logic             data_acc, data_wr, stat_rd, start, collide, clr;

  spi_in_sync #(.N(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck_i, ss_n_i, mosi_i}),
    .q     ({sck_s, ss_s, mosi_s})
  );

  spi_rate_gen #(.CW(HALF_W)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (eng_busy && ctrl_q.master),
    .half  (half_period(dbl_q, ctrl_q.rate)),
    .tick  (tick)
  );

  assign ss_act = ctrl_q.enable && !ctrl_q.master && !ss_s;

  always_comb begin
    data_acc = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
    data_wr  = reg_wr && (reg_addr == ADDR_DATA);
    stat_rd  = reg_rd && (reg_addr == ADDR_STAT);
    start    = data_wr && ctrl_q.enable && !eng_busy;
    collide  = data_wr && ctrl_q.enable && eng_busy;
    clr      = data_acc && armed_q;
  end

  spi_shift_engine #(.DW(REG_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (ctrl_q.enable),
    .master    (ctrl_q.master),
    .cpol      (ctrl_q.cpol),
    .cpha      (ctrl_q.cpha),
    .lsb_first (ctrl_q.lsb_first),
    .load      (start),
    .load_data (reg_wdata),
    .tick      (tick),
    .sck_s     (sck_s),
    .ss_act    (ss_act),
    .mosi_s    (mosi_s),
    .miso_i    (miso_i),
    .busy      (eng_busy),
    .done      (eng_done),
    .rx_data   (rx_data),
    .sck_o     (sck_o),
    .dout      (dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      dbl_q   <= 1'b0;
      spif_q  <= 1'b0;
      wcol_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
      if (reg_wr && reg_addr == ADDR_STAT) dbl_q  <= reg_wdata[0];

      if (eng_done) spif_q <= 1'b1;
      else if (clr) spif_q <= 1'b0;

      if (collide)  wcol_q <= 1'b1;
      else if (clr) wcol_q <= 1'b0;

      if (clr)                              armed_q <= 1'b0;
      else if (stat_rd && (spif_q || wcol_q)) armed_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_q;
      ADDR_STAT: reg_rdata = {spif_q, wcol_q, 5'b0, dbl_q};
      ADDR_DATA: reg_rdata = rx_data;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq     = ctrl_q.irq_en && spif_q;
  assign sck_oe  = ctrl_q.enable && ctrl_q.master;
  assign mosi_oe = ctrl_q.enable && ctrl_q.master;
  assign mosi_o  = dout;
  assign miso_o  = dout;
  assign miso_oe = ss_act;

  // R7: a data write that hits a running transfer raises the collision flag.
  a_r7_collision_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ctrl_q.enable && eng_busy) |=> wcol_q);

  // R6: the engine's completion always reaches the status flag.
  a_r6_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> spif_q);

  // R8: an armed data access clears completion unless a new one lands.
  a_r8_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && armed_q && !eng_done) |=> !spif_q);

endmodule

// File: tb/spi_regif_ctrl_test.sv
module spi_regif_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int SLV_HALF   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;
  logic       miso_i;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regif_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_i(miso_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_o(miso_o), .miso_oe(miso_oe)
  );

  // Bench slave model for master-mode tests.
  logic [7:0] m_tx = 8'h00, m_rx = 8'h00;
  logic       m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0, m_active = 1'b0;
  int         m_gen = 0, m_seen = 0, m_k = 0;

  assign miso_i = m_lsb ? m_tx[(m_k > 7) ? 7 : m_k] : m_tx[7 - ((m_k > 7) ? 7 : m_k)];

  always @(sck_o or m_gen) begin
    if (m_gen != m_seen) begin
      m_seen = m_gen;
      m_k    = 0;
      m_rx   = 8'h00;
    end else if (m_active) begin
      if ((sck_o != m_cpol) != m_cpha)
        m_rx = m_lsb ? {mosi_o, m_rx[7:1]} : {m_rx[6:0], mosi_o};
      if (sck_o == m_cpol) m_k = m_k + 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(string tag);
    logic [7:0] s;
    int n = 0;
    do begin peek(2'd1, s); n++; end while (!s[7] && n < 4000);
    check({tag, " completion"}, s[7], 1'b1);
  endtask

  task automatic clear_flags();
    logic [7:0] d;
    reg_read(2'd1, d);
    reg_read(2'd2, d);
  endtask

  // Master transfer against the bench slave model.
  task automatic m_xfer(logic [7:0] tx, logic [7:0] slv, logic cpol, logic cpha,
                        logic lsb, logic [2:0] code, string tag);
    logic [7:0] d;
    reg_write(2'd0, {1'b0, 1'b1, lsb, 1'b1, cpol, cpha, code[1:0]});
    reg_write(2'd1, {7'b0, code[2]});
    @(negedge clk);
    check({tag, " R4 idle sck"}, sck_o, cpol);
    m_tx = slv; m_cpol = cpol; m_cpha = cpha; m_lsb = lsb;
    m_gen++;
    #1 m_active = 1'b1;
    reg_write(2'd2, tx);
    wait_done(tag);
    m_active = 1'b0;
    check({tag, " R5 bits seen by slave"}, m_rx, tx);
    reg_read(2'd1, d);
    reg_read(2'd2, d);
    check({tag, " R6 received byte"}, d, slv);
    peek(2'd1, d);
    check({tag, " R8 flags cleared"}, d, {7'b0, code[2]});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(2'd0, d); check("R1 ctrl reset", d, 8'h00);
    peek(2'd1, d); check("R1 status reset", d, 8'h00);
    peek(2'd2, d); check("R1 data reset", d, 8'h00);
    check("R1 irq reset", irq, 1'b0);
    check("R1 sck reset", sck_o, 1'b0);
    check("R1 miso_oe reset", miso_oe, 1'b0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    reg_write(2'd0, 8'h9B);
    peek(2'd0, d); check("R2 ctrl readback", d, 8'h9B);
    reg_write(2'd1, 8'hFF);
    peek(2'd1, d); check("R2 status writable bits", d, 8'h01);
    reg_write(2'd1, 8'h00);
    reg_write(2'd0, 8'h00);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 2; o++) begin
        logic [7:0] tx, slv;
        tx  = 8'h1D + 8'(m * 34) + 8'(o * 81);
        slv = 8'hA6 ^ 8'(m * 19 + o * 7);
        m_xfer(tx, slv, m[1], m[0], o[0], 3'b000, $sformatf("R4 R5 mode%0d order%0d", m, o));
      end
    end
  endtask

  task automatic t_timing();
    reg_write(2'd0, 8'h50);
    reg_write(2'd1, 8'h00);
    reg_write(2'd2, 8'h6A);
    reg_addr = 2'd1;
    repeat (31) @(negedge clk);
    #1 check("R6 flag not before 32 clocks", reg_rdata[7], 1'b0);
    @(negedge clk);
    #1 check("R6 flag at 32 clocks", reg_rdata[7], 1'b1);
    check("R4 sck back to idle", sck_o, 1'b0);
    clear_flags();
  endtask

  task automatic t_rates();
    int expn[8] = '{4, 16, 64, 128, 2, 8, 32, 64};
    for (int c = 0; c < 8; c++) begin
      int n = 0;
      logic prev;
      reg_write(2'd0, {6'b010100, 2'(c)});
      reg_write(2'd1, {7'b0, c[2]});
      reg_write(2'd2, 8'h55);
      do @(negedge clk); while (sck_o !== 1'b1);
      prev = 1'b1;
      forever begin
        @(negedge clk);
        n++;
        if (sck_o && !prev) break;
        prev = sck_o;
      end
      check($sformatf("R3 sck period code %0d", c), n, expn[c]);
      wait_done("R3");
      clear_flags();
    end
    reg_write(2'd1, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    reg_write(2'd0, 8'h51);
    m_tx = 8'h3E; m_cpol = 1'b0; m_cpha = 1'b0; m_lsb = 1'b0;
    m_gen++;
    #1 m_active = 1'b1;
    reg_write(2'd2, 8'hC5);
    repeat (20) @(negedge clk);
    reg_write(2'd2, 8'h0F);
    peek(2'd1, d);
    check("R7 collision flag", d[6], 1'b1);
    check("R7 no completion yet", d[7], 1'b0);
    wait_done("R7");
    m_active = 1'b0;
    check("R7 line kept first byte", m_rx, 8'hC5);
    peek(2'd2, d);
    check("R7 received unaffected", d, 8'h3E);
    clear_flags();
    peek(2'd1, d);
    check("R7 R8 both flags cleared", d[7:6], 2'b00);
  endtask

  task automatic t_clear_irq();
    logic [7:0] d;
    m_xfer(8'h81, 8'h24, 1'b0, 1'b0, 1'b0, 3'b000, "R8 setup");
    reg_write(2'd2, 8'h42);
    wait_done("R8");
    check("R9 irq low while disabled", irq, 1'b0);
    reg_read(2'd2, d);
    peek(2'd1, d);
    check("R8 data read alone keeps flag", d[7], 1'b1);
    reg_write(2'd0, 8'hD0);
    @(negedge clk);
    check("R9 irq with enable and flag", irq, 1'b1);
    reg_read(2'd1, d);
    peek(2'd1, d);
    check("R8 status read alone keeps flag", d[7], 1'b1);
    reg_read(2'd2, d);
    peek(2'd1, d);
    check("R8 status then data clears", d[7], 1'b0);
    check("R9 irq drops with flag", irq, 1'b0);
    reg_write(2'd0, 8'h00);
  endtask

  task automatic t_master_ss();
    ss_n_i = 1'b0;
    m_xfer(8'hB2, 8'h4D, 1'b1, 1'b0, 1'b0, 3'b101, "R11 select low");
    ss_n_i = 1'b1;
    m_xfer(8'h17, 8'hE9, 1'b0, 1'b1, 1'b1, 3'b100, "R11 select high");
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    reg_write(2'd0, 8'h10);
    reg_write(2'd2, 8'hAA);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sck_o !== 1'b0) begin check("R12 sck still", sck_o, 1'b0); break; end
    end
    check("R12 sck quiet", sck_o, 1'b0);
    peek(2'd1, d);
    check("R12 no completion", d[7], 1'b0);
  endtask

  // Bench acts as master for slave-mode tests (MSB first).
  task automatic s_xfer(logic [7:0] mtx, logic [7:0] stx, logic cpol, logic cpha, string tag);
    logic [7:0] got = 8'h00, d;
    reg_write(2'd0, {2'b01, 2'b00, cpol, cpha, 2'b00});
    sck_i = cpol;
    repeat (4) @(negedge clk);
    reg_write(2'd2, stx);
    ss_n_i = 1'b0;
    repeat (SLV_HALF) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        mosi_i = mtx[i];
        repeat (SLV_HALF) @(negedge clk);
        got = {got[6:0], miso_o};
        sck_i = ~cpol;
        repeat (SLV_HALF) @(negedge clk);
        sck_i = cpol;
      end else begin
        repeat (SLV_HALF) @(negedge clk);
        sck_i = ~cpol;
        mosi_i = mtx[i];
        repeat (SLV_HALF) @(negedge clk);
        got = {got[6:0], miso_o};
        sck_i = cpol;
      end
    end
    repeat (SLV_HALF) @(negedge clk);
    ss_n_i = 1'b1;
    peek(2'd1, d);
    check({tag, " R10 completion"}, d[7], 1'b1);
    check({tag, " R5 slave sent"}, got, stx);
    reg_read(2'd1, d);
    reg_read(2'd2, d);
    check({tag, " R6 slave received"}, d, mtx);
  endtask

  task automatic t_slave();
    logic [7:0] d;
    s_xfer(8'h9C, 8'h35, 1'b0, 1'b0, "mode0");
    s_xfer(8'h2B, 8'hD4, 1'b1, 1'b1, "mode3");
    reg_write(2'd0, 8'h40);
    sck_i = 1'b0;
    ss_n_i = 1'b1;
    for (int i = 0; i < 16; i++) begin
      mosi_i = i[1];
      repeat (SLV_HALF) @(negedge clk);
      sck_i = ~sck_i;
    end
    repeat (SLV_HALF) @(negedge clk);
    peek(2'd1, d);
    check("R10 deselected edges ignored", d[7], 1'b0);
    check("R10 miso not driven", miso_oe, 1'b0);
    s_xfer(8'h61, 8'h8E, 1'b0, 1'b0, "after deselect");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_modes();
    t_timing();
    t_rates();
    t_collision();
    t_clear_irq();
    t_master_ss();
    t_disabled();
    t_slave();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule